// File: doc/BRIEF.md
# Piecewise-Linear Temperature Converter

This block turns raw 6-bit codes from a shared current-measurement ADC into signed temperatures for two sources. One source is an external negative-coefficient thermistor. The other is an on-die reference whose output is proportional to absolute temperature. The ADC runs continuously. The block decides which source the ADC looks at through `adc_sel`, holds that choice for a programmable number of cycles, and then latches `adc_code` as a sample of that source. It flips to the other source at the same clock edge, so the two sources alternate.

An external sample is converted with a programmable four-segment piecewise-linear table. An internal sample uses a single straight line. Both use one shared multiply-add datapath, and the result is clamped to the 12-bit output range. Each source has its own result register, which keeps its value between updates. A one-cycle strobe marks every update. Downstream reporting and protection logic can therefore read the latest temperatures at any time. All coefficients and the mux period are loaded through a simple write port.

Top module: `tconv_top`

## Requirements
- R1: While `rst` is high and after it, before the first result, `adc_sel` is 0 (external), both strobes are 0 and both temperatures are 0. The reset table has all slopes and offsets at 0, breakpoints 16/32/48, and a period of 7.
- R2: `adc_sel` holds each value for PERIOD+1 cycles and then inverts. The edge at which it inverts is the sample edge. At that edge `adc_code` is captured as a sample of the source that was selected just before the edge.
- R3: The result of a sample appears one clock edge after its sample edge. In the cycle after that edge the strobe of that source (`ext_vld` for `adc_sel`=0, `int_vld` for 1) is high for exactly one cycle, and the other strobe is low.
- R4: The external segment index s is the number of breakpoints B1..B3 that are less than or equal to the code, and B0 is 0. A code equal to a breakpoint therefore uses the upper segment.
- R5: An external result is OFF[s] + floor(SLOPE[s] × (code − B[s]) / 16). SLOPE is 12-bit two's complement with 4 fraction bits. OFF is 12-bit two's complement in 0.125 °C units.
- R6: An internal result is IOFF + floor(ISLOPE × code / 16), with the same formats as R5.
- R7: Any result above 2047 is output as 2047, and any result below −2048 is output as −2048.
- R8: Write-port map, using the low bits of `cfg_wdata`:
  - addresses 0–3: SLOPE[0..3]
  - addresses 4–7: OFF[0..3]
  - addresses 8–10: B1..B3 (6 bits)
  - address 11: ISLOPE
  - address 12: IOFF
  - address 13: PERIOD (16 bits)
  - addresses 14 and 15: ignored
- R9: A write that lands on any edge after a sample edge does not change that sample's result. It applies from the next sample on.
- R10: The two strobes are never high together. Each temperature output changes only on an edge that raises its own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enable for the coefficient port |
| cfg_addr | input | 4 | Write address (map in R8) |
| cfg_wdata | input | 16 | Write data |
| adc_code | input | 6 | Current ADC code, 0 to 63 |
| adc_sel | output | 1 | Source routed to the ADC: 0 external, 1 internal |
| ext_temp | output | 12 | Latest external temperature, signed, 0.125 °C units |
| ext_vld | output | 1 | One-cycle strobe on external update |
| int_temp | output | 12 | Latest internal temperature, signed, 0.125 °C units |
| int_vld | output | 1 | One-cycle strobe on internal update |

## Verification
A sample edge is visible at the ports as the edge that inverts `adc_sel`. The result and strobe for that sample are due exactly one edge later, and the strobe must have dropped one edge after that. The bench finds each inversion on the following falling edge, which also lets it count the PERIOD+1 hold. It computes the expected value at that point from its own copy of the table, before any write that lands afterwards. It then checks the strobes and the temperature on the next falling edge, and the hold on the one after. Every coefficient write is issued at the falling edge just after a sample edge, so the bench always knows which sample a write can affect.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  localparam int NSEG     = 4;
  localparam int A_SLOPE  = 0;
  localparam int A_OFFS   = NSEG;
  localparam int A_BRK    = 2 * NSEG;
  localparam int A_ISLOPE = 3 * NSEG - 1;
  localparam int A_IOFFS  = 3 * NSEG;
  localparam int A_PERIOD = 3 * NSEG + 1;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } src_e;
endpackage

// File: rtl/tconv_regs.sv
module tconv_regs
  import tconv_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int TEMP_W     = 12,
  parameter int SLOPE_W    = 12,
  parameter int DIV_W      = 16,
  parameter int CFG_AW     = 4,
  parameter int CFG_DW     = 16,
  parameter int DEF_PERIOD = 7
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [CFG_AW-1:0]               addr,
  input  logic [CFG_DW-1:0]               wdata,
  output logic [NSEG:0][SLOPE_W-1:0]      slope_o,
  output logic [NSEG:0][TEMP_W-1:0]       offs_o,
  output logic [NSEG-1:0][CODE_W-1:0]     brk_o,
  output logic [DIV_W-1:0]                period_o
);
  // entry NSEG of slope/offset holds the internal straight-line fit
  logic [NSEG:0][SLOPE_W-1:0]  slope_q;
  logic [NSEG:0][TEMP_W-1:0]   offs_q;
  logic [NSEG-1:0][CODE_W-1:0] brk_q;
  logic [DIV_W-1:0]            period_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= NSEG; i++) begin
        slope_q[i] <= '0;
        offs_q[i]  <= '0;
      end
      for (int j = 0; j < NSEG; j++) begin
        brk_q[j] <= CODE_W'((j << CODE_W) / NSEG);
      end
      period_q <= DIV_W'(DEF_PERIOD);
    end else if (we) begin
      for (int i = 0; i < NSEG; i++) begin
        if (addr == CFG_AW'(A_SLOPE + i)) slope_q[i] <= wdata[SLOPE_W-1:0];
        if (addr == CFG_AW'(A_OFFS + i))  offs_q[i]  <= wdata[TEMP_W-1:0];
      end
      // breakpoint 0 is fixed at code 0
      for (int j = 1; j < NSEG; j++) begin
        if (addr == CFG_AW'(A_BRK + j - 1)) brk_q[j] <= wdata[CODE_W-1:0];
      end
      if (addr == CFG_AW'(A_ISLOPE)) slope_q[NSEG] <= wdata[SLOPE_W-1:0];
      if (addr == CFG_AW'(A_IOFFS))  offs_q[NSEG]  <= wdata[TEMP_W-1:0];
      if (addr == CFG_AW'(A_PERIOD)) period_q      <= wdata[DIV_W-1:0];
    end
  end

  assign slope_o  = slope_q;
  assign offs_o   = offs_q;
  assign brk_o    = brk_q;
  assign period_o = period_q;
endmodule

// File: rtl/tconv_sched.sv
module tconv_sched
  import tconv_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] period_i,
  output logic             stb_o,
  output src_e             sel_o
);
  logic [DIV_W-1:0] cnt_q;
  src_e             sel_q;

  // >= keeps the slot bounded if the period shrinks below the count
  assign stb_o = (cnt_q >= period_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sel_q <= SRC_EXT;
    end else if (stb_o) begin
      cnt_q <= '0;
      sel_q <= (sel_q == SRC_EXT) ? SRC_INT : SRC_EXT;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/tconv_snap.sv
module tconv_snap
  import tconv_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int TEMP_W  = 12,
  parameter int SLOPE_W = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        stb_i,
  input  src_e                        sel_i,
  input  logic [CODE_W-1:0]           code_i,
  input  logic [NSEG:0][SLOPE_W-1:0]  slope_i,
  input  logic [NSEG:0][TEMP_W-1:0]   offs_i,
  input  logic [NSEG-1:0][CODE_W-1:0] brk_i,
  output logic                        vld_o,
  output src_e                        src_o,
  output logic signed [SLOPE_W-1:0]   slope_o,
  output logic signed [TEMP_W-1:0]    offs_o,
  output logic signed [CODE_W:0]      delta_o
);
  localparam int SEG_W = $clog2(NSEG);

  logic [SEG_W-1:0]   seg;
  logic [SLOPE_W-1:0] pick_slope;
  logic [TEMP_W-1:0]  pick_offs;
  logic [CODE_W-1:0]  pick_base;
  logic [CODE_W:0]    delta;

  // segment = number of breakpoints at or below the code
  always_comb begin
    seg = '0;
    for (int j = 1; j < NSEG; j++) begin
      if (code_i >= brk_i[j]) seg = seg + SEG_W'(1);
    end
  end

  always_comb begin
    if (sel_i == SRC_INT) begin
      pick_slope = slope_i[NSEG];
      pick_offs  = offs_i[NSEG];
      pick_base  = '0;
    end else begin
      pick_slope = slope_i[seg];
      pick_offs  = offs_i[seg];
      pick_base  = brk_i[seg];
    end
    delta = {1'b0, code_i} - {1'b0, pick_base};
  end

  // coefficients are frozen here, so later writes miss this sample
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o   <= 1'b0;
      src_o   <= SRC_EXT;
      slope_o <= '0;
      offs_o  <= '0;
      delta_o <= '0;
    end else begin
      vld_o <= stb_i;
      if (stb_i) begin
        src_o   <= sel_i;
        slope_o <= pick_slope;
        offs_o  <= pick_offs;
        delta_o <= delta;
      end
    end
  end
endmodule

// File: rtl/tconv_calc.sv
module tconv_calc
  import tconv_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int TEMP_W     = 12,
  parameter int SLOPE_W    = 12,
  parameter int SLOPE_FRAC = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      vld_i,
  input  src_e                      src_i,
  input  logic signed [SLOPE_W-1:0] slope_i,
  input  logic signed [TEMP_W-1:0]  offs_i,
  input  logic signed [CODE_W:0]    delta_i,
  output logic [TEMP_W-1:0]         ext_temp_o,
  output logic                      ext_vld_o,
  output logic [TEMP_W-1:0]         int_temp_o,
  output logic                      int_vld_o
);
  localparam int PROD_W = SLOPE_W + CODE_W + 1;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (TEMP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = ~SAT_HI;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic signed [SUM_W-1:0]  sum;
  logic signed [SUM_W-1:0]  clip;

  always_comb begin
    prod   = slope_i * delta_i;
    scaled = prod >>> SLOPE_FRAC;
    sum    = {{(SUM_W - TEMP_W){offs_i[TEMP_W-1]}}, offs_i}
           + {{(SUM_W - PROD_W){scaled[PROD_W-1]}}, scaled};
    if (sum > SAT_HI)      clip = SAT_HI;
    else if (sum < SAT_LO) clip = SAT_LO;
    else                   clip = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_temp_o <= '0;
      int_temp_o <= '0;
      ext_vld_o  <= 1'b0;
      int_vld_o  <= 1'b0;
    end else begin
      ext_vld_o <= vld_i && (src_i == SRC_EXT);
      int_vld_o <= vld_i && (src_i == SRC_INT);
      if (vld_i && src_i == SRC_EXT) ext_temp_o <= clip[TEMP_W-1:0];
      if (vld_i && src_i == SRC_INT) int_temp_o <= clip[TEMP_W-1:0];
    end
  end
endmodule

// File: rtl/tconv_top.sv
module tconv_top
  import tconv_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int TEMP_W     = 12,
  parameter int SLOPE_W    = 12,
  parameter int SLOPE_FRAC = 4,
  parameter int DIV_W      = 16,
  parameter int CFG_AW     = 4,
  parameter int CFG_DW     = 16,
  parameter int DEF_PERIOD = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [CODE_W-1:0] adc_code,
  output logic              adc_sel,
  output logic [TEMP_W-1:0] ext_temp,
  output logic              ext_vld,
  output logic [TEMP_W-1:0] int_temp,
  output logic              int_vld
);
  logic [NSEG:0][SLOPE_W-1:0]  tbl_slope;
  logic [NSEG:0][TEMP_W-1:0]   tbl_offs;
  logic [NSEG-1:0][CODE_W-1:0] tbl_brk;
  logic [DIV_W-1:0]            period;
  logic                        smp_stb;
  src_e                        src_sel;
  logic                        s1_vld;
  src_e                        s1_src;
  logic signed [SLOPE_W-1:0]   s1_slope;
  logic signed [TEMP_W-1:0]    s1_offs;
  logic signed [CODE_W:0]      s1_delta;

  tconv_regs #(
    .CODE_W(CODE_W), .TEMP_W(TEMP_W), .SLOPE_W(SLOPE_W), .DIV_W(DIV_W),
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .DEF_PERIOD(DEF_PERIOD)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .slope_o(tbl_slope), .offs_o(tbl_offs), .brk_o(tbl_brk), .period_o(period)
  );

  tconv_sched #(.DIV_W(DIV_W)) u_sched (
    .clk(clk), .rst(rst), .period_i(period), .stb_o(smp_stb), .sel_o(src_sel)
  );

  tconv_snap #(.CODE_W(CODE_W), .TEMP_W(TEMP_W), .SLOPE_W(SLOPE_W)) u_snap (
    .clk(clk), .rst(rst), .stb_i(smp_stb), .sel_i(src_sel), .code_i(adc_code),
    .slope_i(tbl_slope), .offs_i(tbl_offs), .brk_i(tbl_brk),
    .vld_o(s1_vld), .src_o(s1_src), .slope_o(s1_slope), .offs_o(s1_offs),
    .delta_o(s1_delta)
  );

  tconv_calc #(
    .CODE_W(CODE_W), .TEMP_W(TEMP_W), .SLOPE_W(SLOPE_W), .SLOPE_FRAC(SLOPE_FRAC)
  ) u_calc (
    .clk(clk), .rst(rst), .vld_i(s1_vld), .src_i(s1_src), .slope_i(s1_slope),
    .offs_i(s1_offs), .delta_i(s1_delta),
    .ext_temp_o(ext_temp), .ext_vld_o(ext_vld),
    .int_temp_o(int_temp), .int_vld_o(int_vld)
  );

  assign adc_sel = (src_sel == SRC_INT);
endmodule

// File: rtl/tconv_chk.sv
module tconv_chk #(
  parameter int TEMP_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              stb,
  input logic              adc_sel,
  input logic              ext_vld,
  input logic              int_vld,
  input logic [TEMP_W-1:0] ext_temp,
  input logic [TEMP_W-1:0] int_temp
);
  assert_sel_flips_R2: assert property (@(posedge clk) disable iff (rst)
    stb |=> (adc_sel != $past(adc_sel)));

  assert_sel_steady_R2: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(adc_sel));

  assert_ext_origin_R3: assert property (@(posedge clk) disable iff (rst)
    ext_vld |-> ($past(stb, 2) && !$past(adc_sel, 2)));

  assert_int_origin_R3: assert property (@(posedge clk) disable iff (rst)
    int_vld |-> ($past(stb, 2) && $past(adc_sel, 2)));

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !(ext_vld && int_vld));

  assert_ext_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ext_vld |-> $stable(ext_temp));

  assert_int_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !int_vld |-> $stable(int_temp));
endmodule

bind tconv_top tconv_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk(clk), .rst(rst), .stb(smp_stb), .adc_sel(adc_sel),
  .ext_vld(ext_vld), .int_vld(int_vld), .ext_temp(ext_temp), .int_temp(int_temp)
);

// File: tb/tconv_top_tb.sv
`timescale 1ns/1ps
module tconv_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [5:0]  adc_code = '0;
  logic        adc_sel;
  logic [11:0] ext_temp;
  logic        ext_vld;
  logic [11:0] int_temp;
  logic        int_vld;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  int m_slope[5];
  int m_off[5];
  int m_bp[4];
  int m_period;

  always #2.5 clk = ~clk;

  tconv_top u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .adc_code(adc_code), .adc_sel(adc_sel),
    .ext_temp(ext_temp), .ext_vld(ext_vld), .int_temp(int_temp), .int_vld(int_vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx12(input logic [15:0] d);
    return int'($signed(d[11:0]));
  endfunction

  function automatic void apply_wr(input int a, input logic [15:0] d);
    if (a <= 3)       m_slope[a] = sx12(d);
    else if (a <= 7)  m_off[a-4] = sx12(d);
    else if (a <= 10) m_bp[a-7] = int'(d[5:0]);
    else if (a == 11) m_slope[4] = sx12(d);
    else if (a == 12) m_off[4] = sx12(d);
    else if (a == 13) m_period = int'(d);
  endfunction

  function automatic int raw_model(input bit src, input int code);
    int s, o, b, seg;
    if (src) begin
      s = m_slope[4]; o = m_off[4]; b = 0;
    end else begin
      seg = 0;
      for (int j = 1; j < 4; j++) if (code >= m_bp[j]) seg++;
      s = m_slope[seg]; o = m_off[seg]; b = (seg == 0) ? 0 : m_bp[seg];
    end
    return o + ((s * (code - b)) >>> 4);
  endfunction

  function automatic int clamp12(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int dir_codes[10] = '{0, 9, 10, 24, 25, 44, 45, 63, 30, 1};
    int dix = 0;
    int gap;
    bit prev_sel;
    bit src;
    int code_now;
    int raw, expv, actv, other;
    bit do_w;
    int wa;
    logic [15:0] wd;
    string tag;
    void'($urandom(32'd4711));

    m_slope = '{0, 0, 0, 0, 0};
    m_off   = '{0, 0, 0, 0, 0};
    m_bp    = '{0, 16, 32, 48};
    m_period = 7;

    repeat (4) @(negedge clk);
    // R1: reset state
    check(adc_sel == 1'b0, "R1 adc_sel", int'(adc_sel), 0);
    check(!ext_vld && !int_vld, "R1 strobes", int'({ext_vld, int_vld}), 0);
    check(ext_temp == 0 && int_temp == 0, "R1 temps", int'(ext_temp) + int'(int_temp), 0);
    code_now = 20;
    adc_code = 6'(code_now);
    rst = 1'b0;
    prev_sel = 1'b0;
    gap = 0;

    for (int it = 0; it < 300; it++) begin
      do begin
        @(negedge clk);
        gap++;
      end while (adc_sel == prev_sel && gap < 100);
      // R2: hold length and inversion
      check(gap == m_period + 1, "R2 period", gap, m_period + 1);
      src = prev_sel;
      raw = raw_model(src, code_now);
      expv = clamp12(raw);
      prev_sel = adc_sel;

      tag = src ? "R6" : "R5";
      if (!src && (code_now == m_bp[1] || code_now == m_bp[2] || code_now == m_bp[3]))
        tag = {tag, " R4"};
      if (raw != expv) tag = {tag, " R7"};
      if (it == 21 || it == 22) tag = {tag, " R8 ignored addr"};

      do_w = 1'b0; wa = 0; wd = '0;
      case (it)
        0:  begin do_w = 1; wa = 0;  wd = 16'(-48);   end
        1:  begin do_w = 1; wa = 1;  wd = 16'(-30);   end
        2:  begin do_w = 1; wa = 2;  wd = 16'(-20);   end
        3:  begin do_w = 1; wa = 3;  wd = 16'(-12);   end
        4:  begin do_w = 1; wa = 4;  wd = 16'(1000);  end
        5:  begin do_w = 1; wa = 5;  wd = 16'(700);   end
        6:  begin do_w = 1; wa = 6;  wd = 16'(400);   end
        7:  begin do_w = 1; wa = 7;  wd = 16'(150);   end
        8:  begin do_w = 1; wa = 8;  wd = 16'(10);    end
        9:  begin do_w = 1; wa = 9;  wd = 16'(25);    end
        10: begin do_w = 1; wa = 10; wd = 16'(45);    end
        11: begin do_w = 1; wa = 11; wd = 16'(37);    end
        12: begin do_w = 1; wa = 12; wd = 16'(-300);  end
        13: begin do_w = 1; wa = 13; wd = 16'(5);     end
        20: begin do_w = 1; wa = 14; wd = 16'($urandom); end
        21: begin do_w = 1; wa = 15; wd = 16'($urandom); end
        30: begin do_w = 1; wa = 3;  wd = 16'(2047);  end
        31: begin do_w = 1; wa = 7;  wd = 16'(2000);  end
        36: begin do_w = 1; wa = 3;  wd = 16'(-2048); end
        37: begin do_w = 1; wa = 7;  wd = 16'(-2000); end
        default: begin
          if (it >= 42 && ($urandom % 3) == 0) begin
            do_w = 1;
            wa = int'($urandom % 16);
            wd = 16'($urandom);
            if (wa == 13) wd = 16'(2 + $urandom % 8);
            if (wa >= 8 && wa <= 10) wd = 16'($urandom % 64);
          end
        end
      endcase
      // write lands on the edge after the sample edge: R9
      if (do_w) begin
        cfg_we = 1'b1; cfg_addr = 4'(wa); cfg_wdata = wd;
        apply_wr(wa, wd);
        tag = {tag, " R9"};
      end

      if (adc_sel == 1'b0 && it < 30 && dix < 10) begin
        code_now = dir_codes[dix]; dix++;
      end else if (adc_sel == 1'b0 && it >= 32 && it < 42) begin
        code_now = 63;
      end else if (($urandom % 4) == 0 && adc_sel == 1'b0) begin
        code_now = m_bp[1 + $urandom % 3];
      end else begin
        code_now = int'($urandom % 64);
      end

      @(negedge clk);
      cfg_we = 1'b0;
      adc_code = 6'(code_now);
      // R3: strobe one edge after the sample edge
      check(src ? (int_vld && !ext_vld) : (ext_vld && !int_vld), "R3 strobe",
            int'({ext_vld, int_vld}), src ? 1 : 2);
      actv = src ? int'($signed(int_temp)) : int'($signed(ext_temp));
      check(actv == expv, tag, actv, expv);
      other = src ? int'($signed(int_temp)) : int'($signed(ext_temp));

      @(negedge clk);
      // R10: strobe drops, value holds
      check(!ext_vld && !int_vld, "R10 strobe width", int'({ext_vld, int_vld}), 0);
      actv = src ? int'($signed(int_temp)) : int'($signed(ext_temp));
      check(actv == other, "R10 hold", actv, other);
      gap = 2;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule